// File: doc/BRIEF.md
# Software-Refilled Set-Associative Address Translator

This block translates 48-bit virtual addresses into physical addresses with a 4-way set-associative translation cache. The cache has 256 sets and maps 16 KiB pages. The block never walks page tables in hardware. Software installs every entry through a fill port. When a translated lookup finds no entry, the block raises a miss toward the interrupt logic, and the handler refills the entry and retries the access.

The top 16 address bits pick how each access is handled:

| Region bits [47:32] | Handling |
|---|---|
| 0x0000 | fault |
| 0x0001-0x3FFF | translated, shared region |
| 0x4000-0x7FFF | translated, per-process region |
| 0x8000-0xBFFF | translated, kernel region |
| 0xC000-0xCFFF | untranslated, cacheable |
| 0xD000-0xDFFF | untranslated, uncached |
| 0xE000-0xEFFF | reserved, fault |
| 0xF000-0xFFFF | untranslated device space |

The set index is normally the low byte of the virtual page number. This keeps neighbouring pages in different sets. In the per-process region, a configuration input can fold the address-space identifier into the index.

Each set replaces its ways in first-in first-out order. Four new pages loaded into one set therefore all stay resident. Clearing the MMU-enable input turns off translation for every address, which is how interrupt handlers run.

A lookup presented in one cycle produces its response in the next cycle. A fill or flush takes effect for lookups issued from the following cycle on.

Top module: `soft_tlb`

## Requirements
- R1: Every cycle with `reqValid` high gives exactly one cycle of `rspValid` on the following cycle, and no response appears otherwise. In each response at most one of `rspHit`, `rspMiss` and `rspFault` is high.
- R2: A translated-region lookup hits when a valid entry in the selected set holds the same virtual page number (bits 47:14) and either its ASID equals `reqAsid` or its global bit is set. The physical address is then {entry PPN, va[13:0]}.
- R3: A translated-region lookup with no matching entry gives `rspMiss`=1, `rspHit`=0, `rspPa`=0, `rspCacheable`=0 and `rspMmio`=0.
- R4: The set index is va[21:14]. In region 0x4000-0x7FFF with `hashLocal`=1, the index is va[21:14] XOR asid[7:0]. Fills use the same rule with their own ASID and the current `hashLocal`.
- R5: Fills of new pages into one set take its ways in FIFO order. Four new pages in a set all stay resident, and a fifth new page evicts the oldest one.
- R6: A fill whose page number and ASID-or-global match an existing entry of its set overwrites that entry. It does not take a new way and evicts nothing.
- R7: With the MMU on, regions 0xC000-0xCFFF, 0xD000-0xDFFF and 0xF000-0xFFFF return `rspPa`=va with no hit, miss or fault. `rspCacheable` is 1 only for 0xC000-0xCFFF, and `rspMmio` is 1 only for 0xF000-0xFFFF.
- R8: With the MMU on, region 0x0000 and region 0xE000-0xEFFF give `rspFault`=1, with `rspPa`=0, `rspCacheable`=0 and `rspMmio`=0.
- R9: With `mmuOn`=0, every address returns `rspPa`=va with no hit, miss or fault. `rspCacheable` is 0 for regions 0xD000-0xFFFF and 1 elsewhere, and `rspMmio` is 1 for 0xF000-0xFFFF.
- R10: A hit on an entry loaded with the uncached flag gives `rspCacheable`=0. Other hits give 1.
- R11: A `flush` invalidates every entry in one cycle. A fill in the same cycle as a flush is dropped.
- R12: After reset no entry is valid and `rspValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request |
| reqVa | input | 48 | Lookup virtual address |
| reqAsid | input | 16 | Current address-space identifier |
| mmuOn | input | 1 | Translation enable |
| hashLocal | input | 1 | Fold ASID into the index in the per-process region |
| fillValid | input | 1 | Install an entry |
| fillVpn | input | 34 | Virtual page number of the new entry |
| fillAsid | input | 16 | ASID of the new entry |
| fillGlobal | input | 1 | New entry matches any ASID |
| fillUncached | input | 1 | New entry's page is uncached |
| fillPpn | input | 34 | Physical page number of the new entry |
| flush | input | 1 | Invalidate all entries |
| rspValid | output | 1 | Response valid |
| rspPa | output | 48 | Physical address |
| rspCacheable | output | 1 | Access may be cached |
| rspMmio | output | 1 | Access targets device space |
| rspHit | output | 1 | Translation found |
| rspMiss | output | 1 | Translation missing, software refill needed |
| rspFault | output | 1 | Access to a forbidden region |

## Verification
The assertions assume that `reqValid` is low throughout reset. This keeps the one-cycle response relation exact from the first edge. The stimulus holds every input low until reset is released.

The assertions make no assumption about how many ways can match at once, since overlapping global and per-ASID entries are software's responsibility. The stimulus therefore never installs a global and a non-global entry for the same page in the same set.

Fills and lookups are never issued in the same cycle. The read-before-write ordering inside a cycle is therefore not relied upon by any expected value.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

  localparam int REGION_W = 16;

  typedef enum logic [2:0] {
    RG_NULL,
    RG_SHARED,
    RG_LOCAL,
    RG_KERNEL,
    RG_PHYS,
    RG_PHYS_NC,
    RG_RSVD,
    RG_DEVICE
  } regionE;

  // Strobes from control to datapath
  typedef struct packed {
    logic lkValid;
    logic lkTranslate;
    logic lkFault;
    logic lkBypassNc;
    logic lkMmio;
    logic fillEn;
    logic flushAll;
  } tlbStrobeT;

  function automatic regionE decodeRegion(input logic [REGION_W-1:0] r);
    regionE res;
    if (r == '0)                res = RG_NULL;
    else if (r < 16'h4000)      res = RG_SHARED;
    else if (r < 16'h8000)      res = RG_LOCAL;
    else if (r < 16'hC000)      res = RG_KERNEL;
    else begin
      case (r[15:12])
        4'hC:    res = RG_PHYS;
        4'hD:    res = RG_PHYS_NC;
        4'hE:    res = RG_RSVD;
        default: res = RG_DEVICE;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
#(
  parameter int SETS = 256,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                mmuOn,
  input  logic                hashLocal,
  input  logic [REGION_W-1:0] reqRegion,
  input  logic [IDX_W-1:0]    reqVpnLow,
  input  logic [IDX_W-1:0]    reqAsidFold,
  input  logic                fillValid,
  input  logic [REGION_W-1:0] fillRegion,
  input  logic [IDX_W-1:0]    fillVpnLow,
  input  logic [IDX_W-1:0]    fillAsidFold,
  input  logic                flush,
  input  logic [WAYS-1:0]     fillMatch,
  output tlbStrobeT           stb,
  output logic [IDX_W-1:0]    lkIdx,
  output logic [IDX_W-1:0]    fillIdx,
  output logic [WAY_W-1:0]    fillWay
);

  regionE reqReg;
  regionE fillReg;
  logic [WAY_W-1:0] fifoPtr [SETS];
  logic [WAY_W-1:0] matchWay;
  logic             matchAny;

  function automatic logic [IDX_W-1:0] pickSet(input regionE r,
                                               input logic [IDX_W-1:0] low,
                                               input logic [IDX_W-1:0] fold,
                                               input logic hash);
    return (r == RG_LOCAL && hash) ? (low ^ fold) : low;
  endfunction

  assign reqReg  = decodeRegion(reqRegion);
  assign fillReg = decodeRegion(fillRegion);
  assign lkIdx   = pickSet(reqReg, reqVpnLow, reqAsidFold, hashLocal);
  assign fillIdx = pickSet(fillReg, fillVpnLow, fillAsidFold, hashLocal);

  // Region handling for the current lookup
  always_comb begin
    stb = '0;
    stb.lkValid  = reqValid;
    stb.flushAll = flush;
    stb.fillEn   = fillValid && !flush;
    if (!mmuOn) begin
      stb.lkBypassNc = (reqReg == RG_PHYS_NC) || (reqReg == RG_RSVD) || (reqReg == RG_DEVICE);
      stb.lkMmio     = (reqReg == RG_DEVICE);
    end else begin
      case (reqReg)
        RG_NULL, RG_RSVD:               stb.lkFault = 1'b1;
        RG_SHARED, RG_LOCAL, RG_KERNEL: stb.lkTranslate = 1'b1;
        RG_PHYS:                        ;
        RG_PHYS_NC:                     stb.lkBypassNc = 1'b1;
        default: begin
          stb.lkBypassNc = 1'b1;
          stb.lkMmio     = 1'b1;
        end
      endcase
    end
  end

  // Victim choice: matching way first, otherwise FIFO slot of the set
  always_comb begin
    matchAny = |fillMatch;
    matchWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fillMatch[w]) matchWay = WAY_W'(w);
    end
  end

  assign fillWay = matchAny ? matchWay : fifoPtr[fillIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) fifoPtr[s] <= '0;
    end else if (stb.flushAll) begin
      for (int s = 0; s < SETS; s++) fifoPtr[s] <= '0;
    end else if (stb.fillEn && !matchAny) begin
      fifoPtr[fillIdx] <= fifoPtr[fillIdx] + 1'b1;
    end
  end

  // R5
  fifo_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush && fillMatch == '0) |=> (fifoPtr[$past(fillIdx)] == $past(fillWay) + 1'b1));

  // R6
  overwrite_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush && fillMatch != '0) |=> $stable(fifoPtr[$past(fillIdx)]));

endmodule

// File: rtl/soft_tlb_dp.sv
module soft_tlb_dp
  import soft_tlb_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 48,
  parameter int PAGE_BITS = 14,
  parameter int SETS      = 256,
  parameter int WAYS      = 4,
  parameter int ASID_W    = 16,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobeT         stb,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillGlobal,
  input  logic              fillUncached,
  input  logic [PPN_W-1:0]  fillPpn,
  output logic [WAYS-1:0]   fillMatch,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPa,
  output logic              rspCacheable,
  output logic              rspMmio,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault
);

  logic [WAYS-1:0]   entValid  [SETS];
  logic [WAYS-1:0]   entGlobal [SETS];
  logic [WAYS-1:0]   entUnc    [SETS];
  logic [VPN_W-1:0]  entVpn    [SETS][WAYS];
  logic [ASID_W-1:0] entAsid   [SETS][WAYS];
  logic [PPN_W-1:0]  entPpn    [SETS][WAYS];

  logic [VPN_W-1:0]  reqVpn;
  logic              hitAny;
  logic [PPN_W-1:0]  hitPpn;
  logic              hitUnc;

  assign reqVpn = reqVa[VA_W-1:PAGE_BITS];

  // Parallel tag compare on the lookup set, lowest way wins
  always_comb begin
    hitAny = 1'b0;
    hitPpn = '0;
    hitUnc = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (entValid[lkIdx][w] && entVpn[lkIdx][w] == reqVpn &&
          (entGlobal[lkIdx][w] || entAsid[lkIdx][w] == reqAsid)) begin
        hitAny = 1'b1;
        hitPpn = entPpn[lkIdx][w];
        hitUnc = entUnc[lkIdx][w];
      end
    end
  end

  // Compare on the fill set to find an entry to overwrite
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      fillMatch[w] = entValid[fillIdx][w] && entVpn[fillIdx][w] == fillVpn &&
                     (entGlobal[fillIdx][w] || entAsid[fillIdx][w] == fillAsid);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) entValid[s] <= '0;
    end else if (stb.flushAll) begin
      for (int s = 0; s < SETS; s++) entValid[s] <= '0;
    end else if (stb.fillEn) begin
      entValid[fillIdx][fillWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillEn) begin
      entVpn[fillIdx][fillWay]    <= fillVpn;
      entAsid[fillIdx][fillWay]   <= fillAsid;
      entPpn[fillIdx][fillWay]    <= fillPpn;
      entGlobal[fillIdx][fillWay] <= fillGlobal;
      entUnc[fillIdx][fillWay]    <= fillUncached;
    end
  end

  // Response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspPa        <= '0;
      rspCacheable <= 1'b0;
      rspMmio      <= 1'b0;
      rspHit       <= 1'b0;
      rspMiss      <= 1'b0;
      rspFault     <= 1'b0;
    end else begin
      rspValid     <= stb.lkValid;
      rspPa        <= '0;
      rspCacheable <= 1'b0;
      rspMmio      <= 1'b0;
      rspHit       <= 1'b0;
      rspMiss      <= 1'b0;
      rspFault     <= 1'b0;
      if (stb.lkValid) begin
        if (stb.lkFault) begin
          rspFault <= 1'b1;
        end else if (stb.lkTranslate) begin
          if (hitAny) begin
            rspHit       <= 1'b1;
            rspPa        <= {hitPpn, reqVa[PAGE_BITS-1:0]};
            rspCacheable <= !hitUnc;
          end else begin
            rspMiss <= 1'b1;
          end
        end else begin
          rspPa        <= reqVa[PA_W-1:0];
          rspCacheable <= !stb.lkBypassNc;
          rspMmio      <= stb.lkMmio;
        end
      end
    end
  end

  logic anyValid;
  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SETS; s++) anyValid = anyValid | (|entValid[s]);
  end

  // R11
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flushAll |=> !anyValid);

  // R1
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspHit, rspMiss, rspFault}));

  // R1
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lkValid |=> rspValid);

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 48,
  parameter int PAGE_BITS = 14,
  parameter int SETS      = 256,
  parameter int WAYS      = 4,
  parameter int ASID_W    = 16,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              mmuOn,
  input  logic              hashLocal,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillGlobal,
  input  logic              fillUncached,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic              flush,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPa,
  output logic              rspCacheable,
  output logic              rspMmio,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  tlbStrobeT        stb;
  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] fillIdx;
  logic [WAY_W-1:0] fillWay;
  logic [WAYS-1:0]  fillMatch;
  logic [IDX_W-1:0] reqAsidFold;
  logic [IDX_W-1:0] fillAsidFold;

  generate
    if (ASID_W >= IDX_W) begin : g_foldTrunc
      assign reqAsidFold  = reqAsid[IDX_W-1:0];
      assign fillAsidFold = fillAsid[IDX_W-1:0];
    end else begin : g_foldPad
      assign reqAsidFold  = {{(IDX_W-ASID_W){1'b0}}, reqAsid};
      assign fillAsidFold = {{(IDX_W-ASID_W){1'b0}}, fillAsid};
    end
  endgenerate

  soft_tlb_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .mmuOn        (mmuOn),
    .hashLocal    (hashLocal),
    .reqRegion    (reqVa[VA_W-1 -: REGION_W]),
    .reqVpnLow    (reqVa[PAGE_BITS +: IDX_W]),
    .reqAsidFold  (reqAsidFold),
    .fillValid    (fillValid),
    .fillRegion   (fillVpn[VPN_W-1 -: REGION_W]),
    .fillVpnLow   (fillVpn[IDX_W-1:0]),
    .fillAsidFold (fillAsidFold),
    .flush        (flush),
    .fillMatch    (fillMatch),
    .stb          (stb),
    .lkIdx        (lkIdx),
    .fillIdx      (fillIdx),
    .fillWay      (fillWay)
  );

  soft_tlb_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
    .SETS(SETS), .WAYS(WAYS), .ASID_W(ASID_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .lkIdx        (lkIdx),
    .fillIdx      (fillIdx),
    .fillWay      (fillWay),
    .reqVa        (reqVa),
    .reqAsid      (reqAsid),
    .fillVpn      (fillVpn),
    .fillAsid     (fillAsid),
    .fillGlobal   (fillGlobal),
    .fillUncached (fillUncached),
    .fillPpn      (fillPpn),
    .fillMatch    (fillMatch),
    .rspValid     (rspValid),
    .rspPa        (rspPa),
    .rspCacheable (rspCacheable),
    .rspMmio      (rspMmio),
    .rspHit       (rspHit),
    .rspMiss      (rspMiss),
    .rspFault     (rspFault)
  );

  // R9
  mmu_off_nomiss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mmuOn) |=> (!rspMiss && !rspFault && !rspHit));

  // R8
  rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mmuOn && reqVa[VA_W-1 -: 4] == 4'hE) |=> rspFault);

endmodule

// File: tb/soft_tlb_tb.sv
module soft_tlb_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [47:0] reqVa = '0;
  logic [15:0] reqAsid = '0;
  logic        mmuOn = 1'b0;
  logic        hashLocal = 1'b0;
  logic        fillValid = 1'b0;
  logic [33:0] fillVpn = '0;
  logic [15:0] fillAsid = '0;
  logic        fillGlobal = 1'b0;
  logic        fillUncached = 1'b0;
  logic [33:0] fillPpn = '0;
  logic        flush = 1'b0;
  logic        rspValid;
  logic [47:0] rspPa;
  logic        rspCacheable, rspMmio, rspHit, rspMiss, rspFault;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        hit, miss, fault, cache, mmio;
    logic [47:0] pa;
    string       tag;
  } expT;
  expT sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_tlb u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa), .reqAsid(reqAsid),
    .mmuOn(mmuOn), .hashLocal(hashLocal), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillAsid(fillAsid), .fillGlobal(fillGlobal), .fillUncached(fillUncached),
    .fillPpn(fillPpn), .flush(flush), .rspValid(rspValid), .rspPa(rspPa),
    .rspCacheable(rspCacheable), .rspMmio(rspMmio), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspFault(rspFault)
  );

  function automatic logic [47:0] mkVa(input logic [15:0] r, input logic [9:0] h,
                                       input logic [7:0] s, input logic [13:0] o);
    return {r, h, s, o};
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops the oldest expectation per response
  always @(negedge clk) begin
    expT e;
    if (rstN && rspValid) begin
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected response, got rspValid=1 expected 0");
      end else begin
        e = sbq.pop_front();
        if (rspHit !== e.hit || rspMiss !== e.miss || rspFault !== e.fault ||
            rspCacheable !== e.cache || rspMmio !== e.mmio || rspPa !== e.pa) begin
          fails++;
          $display("FAIL %s: hmfcm=%b%b%b%b%b pa=%h expected hmfcm=%b%b%b%b%b pa=%h",
                   e.tag, rspHit, rspMiss, rspFault, rspCacheable, rspMmio, rspPa,
                   e.hit, e.miss, e.fault, e.cache, e.mmio, e.pa);
        end
      end
    end
  end

  task automatic lk(input logic [47:0] va, input logic [15:0] asid, input logic mmu,
                    input logic hash, input logic eHit, input logic eMiss, input logic eFault,
                    input logic [47:0] ePa, input logic eCache, input logic eMmio,
                    input string tag);
    expT e;
    @(negedge clk);
    reqValid  = 1'b1;
    reqVa     = va;
    reqAsid   = asid;
    mmuOn     = mmu;
    hashLocal = hash;
    e.hit = eHit; e.miss = eMiss; e.fault = eFault;
    e.cache = eCache; e.mmio = eMmio; e.pa = ePa; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic lkHit(input logic [47:0] va, input logic [15:0] asid, input logic hash,
                       input logic [33:0] ppn, input logic unc, input string tag);
    lk(va, asid, 1'b1, hash, 1'b1, 1'b0, 1'b0, {ppn, va[13:0]}, !unc, 1'b0, tag);
  endtask

  task automatic lkMiss(input logic [47:0] va, input logic [15:0] asid, input logic hash,
                        input string tag);
    lk(va, asid, 1'b1, hash, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic lkPass(input logic [47:0] va, input logic mmu, input logic cache,
                        input logic mmio, input string tag);
    lk(va, 16'h0005, mmu, 1'b0, 1'b0, 1'b0, 1'b0, va, cache, mmio, tag);
  endtask

  task automatic fill(input logic [47:0] va, input logic [15:0] asid, input logic glob,
                      input logic unc, input logic [33:0] ppn, input logic hash,
                      input logic withFlush);
    @(negedge clk);
    reqValid     = 1'b0;
    hashLocal    = hash;
    fillValid    = 1'b1;
    fillVpn      = va[47:14];
    fillAsid     = asid;
    fillGlobal   = glob;
    fillUncached = unc;
    fillPpn      = ppn;
    flush        = withFlush;
    @(negedge clk);
    fillValid = 1'b0;
    flush     = 1'b0;
  endtask

  task automatic doFlush;
    @(negedge clk);
    reqValid = 1'b0;
    flush    = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL R1: watchdog expired, got no completion expected completion");
    report();
    $finish;
  end

  initial begin
    logic [47:0] vaA, vaB, vaL;
    vaA = mkVa(16'h0001, 10'd1, 8'h10, 14'h0123);
    vaB = mkVa(16'h0001, 10'd2, 8'h11, 14'h3FFF);
    vaL = mkVa(16'h4000, 10'd0, 8'h40, 14'h0042);

    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
      fails++;
      $display("FAIL R12: rspValid=%b rspHit=%b expected 0 0", rspValid, rspHit);
    end
    rstN = 1'b1;

    lkMiss(vaA, 16'h0005, 1'b0, "R12/R3 empty after reset");
    fill(vaA, 16'h0005, 1'b0, 1'b0, 34'h2AAAA, 1'b0, 1'b0);
    lkHit(vaA, 16'h0005, 1'b0, 34'h2AAAA, 1'b0, "R2 asid hit");
    lkMiss(vaA, 16'h0006, 1'b0, "R2 asid mismatch miss");
    fill(vaB, 16'h0005, 1'b1, 1'b1, 34'h00155, 1'b0, 1'b0);
    lkHit(vaB, 16'h0009, 1'b0, 34'h00155, 1'b1, "R10 global uncached hit");

    // R11 flush
    doFlush();
    lkMiss(vaA, 16'h0005, 1'b0, "R11 flush removed A");
    lkMiss(vaB, 16'h0009, 1'b0, "R11 flush removed B");

    // R5 FIFO in set 0x20 of the kernel region
    for (int k = 1; k <= 4; k++)
      fill(mkVa(16'h8000, 10'(k), 8'h20, 14'h0), 16'h0005, 1'b0, 1'b0, 34'(32'h100 + k), 1'b0, 1'b0);
    for (int k = 1; k <= 4; k++)
      lkHit(mkVa(16'h8000, 10'(k), 8'h20, 14'h0777), 16'h0005, 1'b0, 34'(32'h100 + k), 1'b0, "R5 four resident");
    fill(mkVa(16'h8000, 10'd5, 8'h20, 14'h0), 16'h0005, 1'b0, 1'b0, 34'h105, 1'b0, 1'b0);
    lkMiss(mkVa(16'h8000, 10'd1, 8'h20, 14'h0), 16'h0005, 1'b0, "R5 oldest evicted");
    lkHit(mkVa(16'h8000, 10'd5, 8'h20, 14'h0001), 16'h0005, 1'b0, 34'h105, 1'b0, "R5 newest resident");

    // R6 overwrite in place
    fill(mkVa(16'h8000, 10'd3, 8'h20, 14'h0), 16'h0005, 1'b0, 1'b0, 34'h777, 1'b0, 1'b0);
    lkHit(mkVa(16'h8000, 10'd3, 8'h20, 14'h0010), 16'h0005, 1'b0, 34'h777, 1'b0, "R6 new ppn");
    lkHit(mkVa(16'h8000, 10'd2, 8'h20, 14'h0010), 16'h0005, 1'b0, 34'h102, 1'b0, "R6 kept way");
    lkHit(mkVa(16'h8000, 10'd4, 8'h20, 14'h0010), 16'h0005, 1'b0, 34'h104, 1'b0, "R6 kept way");
    lkHit(mkVa(16'h8000, 10'd5, 8'h20, 14'h0010), 16'h0005, 1'b0, 34'h105, 1'b0, "R6 kept way");

    // R4 ASID-hashed index in the per-process region
    fill(vaL, 16'h0003, 1'b1, 1'b0, 34'h321, 1'b1, 1'b0);
    lkHit(vaL, 16'h0003, 1'b1, 34'h321, 1'b0, "R4 hashed hit");
    lkMiss(vaL, 16'h0004, 1'b1, "R4 other asid other set");
    lkMiss(vaL, 16'h0004, 1'b0, "R4 plain index other set");
    fill(vaL, 16'h0004, 1'b0, 1'b0, 34'h654, 1'b0, 1'b0);
    lkHit(vaL, 16'h0004, 1'b0, 34'h654, 1'b0, "R4 plain hit");
    lkHit(vaL, 16'h0003, 1'b1, 34'h321, 1'b0, "R4 hashed entry kept");

    // R7 bypass regions
    lkPass(48'hC123_89AB_CDEF, 1'b1, 1'b1, 1'b0, "R7 phys cached");
    lkPass(48'hD000_1234_5678, 1'b1, 1'b0, 1'b0, "R7 phys uncached");
    lkPass(48'hF001_0000_0040, 1'b1, 1'b0, 1'b1, "R7 device");

    // R8 faults
    lk(48'h0000_0000_4000, 16'h0005, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b0, 1'b0, "R8 null region");
    lk(48'hE555_0000_0000, 16'h0005, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b0, 1'b0, "R8 reserved");

    // R9 MMU off
    lkPass(vaA, 1'b0, 1'b1, 1'b0, "R9 translated region untranslated");
    lkPass(48'h0000_0000_4000, 1'b0, 1'b1, 1'b0, "R9 null region passes");
    lkPass(48'hE000_0000_1000, 1'b0, 1'b0, 1'b0, "R9 reserved passes uncached");
    lkPass(48'hF000_0000_0008, 1'b0, 1'b0, 1'b1, "R9 device");

    // R11 flush beats fill
    fill(vaA, 16'h0005, 1'b0, 1'b0, 34'h1, 1'b0, 1'b1);
    lkMiss(vaA, 16'h0005, 1'b0, "R11 fill dropped under flush");
    lkMiss(vaL, 16'h0003, 1'b1, "R11 all cleared");

    // R1 idle gap gives no response
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || sbq.size() != 0) begin
      fails++;
      $display("FAIL R1: rspValid=%b pending=%0d expected 0 0", rspValid, sbq.size());
    end

    report();
    $finish;
  end

endmodule